// File: doc/BRIEF.md
# Serial Byte Memory Slave with Transfer Pause

This block is a byte-wide nonvolatile-style memory that a host reaches over a mode-0 SPI link. The host pulls chip select low. It then shifts in an opcode, a 16-bit address and data on the serial input, and takes read data from the serial output. Writes land in the array at once. There is no erase phase and no busy flag, so a write cycle costs the same as a read cycle.

A write-enable latch guards every write to the array and to the status register. A two-bit block-protect field locks part of the array: none of it, the upper quarter, the upper half, or all of it. A status lock bit, together with the write-protect pin, can freeze the status register. A pause input lets the host stop a transfer in the middle of a frame without releasing chip select, and resume it later.

The serial pins are sampled by the system clock, and the block detects the SCK edges itself. The SCK half period must therefore span at least three system clocks. The full 32K x 8 part uses `ADDR_W = 15`; the default build uses `ADDR_W = 11`, which gives a 2K x 8 array.

Top module: `sermem_slave`

## Requirements
- R1: Opcode, address and write data are taken MSB first on rising SCK. The address is 16 bits, and any bits above ADDR_W are ignored. Read data is driven on `so` MSB first, and it changes after falling SCK edges.
- R2: READ (0x03) returns the byte at the address. It then returns successive bytes, and the address wraps from the top of the array to 0x0000.
- R3: WRITE (0x02) stores each data byte and auto-increments the address with the same wrap. It has no effect when the write-enable latch is clear.
- R4: WREN (0x06) sets the write-enable latch, and WRDI (0x04) clears it. Raising chip select after a completed WRITE or WRSR also clears it.
- R5: RDSR (0x05) returns the status byte. Bit 7 is the lock enable, bits 3:2 are the protect field, bit 1 is the latch, and all other bits are 0. After reset the status byte is 0x00.
- R6: WRSR (0x01) loads status bits 7 and 3:2, but only while the latch is set. It is refused when bit 7 is set and `wp_n` is low.
- R7: The protect field selects the locked region: 00 none, 01 the upper quarter, 10 the upper half, 11 the whole array. A write into a locked address is dropped, but the address still advances.
- R8: `so_oe` is low while chip select is high, during the opcode and address phases, and for any unknown opcode.
- R9: While `hold_n` is low, `so_oe` is low and SCK and SI are ignored. The bit position is kept, and the transfer resumes when `hold_n` rises.
- R10: An unknown opcode has no effect on the latch, the status byte or the array until chip select rises.
- R11: A data byte whose last rising SCK edge is followed one system clock later by chip select rising is still written, and the latch is cleared.
- R12: A READ issued straight after a WRITE returns the new data, with no wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from host |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Transfer pause, active low |
| wp_n | input | 1 | Write protect, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so`; low means high impedance |

## Verification
Two events can fall on the same system clock: completion of the last data byte of a write, and the deselect that ends the transaction. The bench provokes this by raising chip select one system clock after the final rising SCK edge. The byte store, the latch clear and the frame reset then all meet in one cycle. The bench judges the result at the ports: a status read must show the latch clear, and a read-back must return the byte.

// File: rtl/sermem_pkg.sv
package sermem_pkg;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  // byte position inside a frame
  typedef enum logic [1:0] {PH_OP, PH_AH, PH_AL, PH_DATA} phase_t;
endpackage

// File: rtl/sermem_port.sv
module sermem_port (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       si,
  input  logic       hold_n,
  input  logic       wp_n,
  input  logic       tx_on,
  input  logic [7:0] tx_byte,
  output logic       desel,
  output logic       wp_q,
  output logic       byte_vld,
  output logic [7:0] byte_data,
  output logic       so,
  output logic       so_oe
);
  logic       cs_q, sck_q, sck_d, si_q, hold_q;
  logic [2:0] bit_cnt;
  logic [6:0] shreg;
  logic       active, rise, fall;

  assign active = !cs_q && hold_q;
  assign rise   = active && sck_q && !sck_d;
  assign fall   = active && !sck_q && sck_d;
  assign desel  = cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q      <= 1'b1;
      sck_q     <= 1'b0;
      sck_d     <= 1'b0;
      si_q      <= 1'b0;
      hold_q    <= 1'b1;
      wp_q      <= 1'b1;
      bit_cnt   <= '0;
      shreg     <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
      so        <= 1'b0;
      so_oe     <= 1'b0;
    end else begin
      cs_q     <= cs_n;
      sck_q    <= sck;
      sck_d    <= sck_q;
      si_q     <= si;
      hold_q   <= hold_n;
      wp_q     <= wp_n;
      byte_vld <= 1'b0;
      if (cs_q) begin
        bit_cnt <= '0;
      end else if (rise) begin
        shreg   <= {shreg[5:0], si_q};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_vld  <= 1'b1;
          byte_data <= {shreg, si_q};
        end
      end
      // bit index 7-bit_cnt: MSB first
      if (fall) so <= tx_byte[~bit_cnt];
      so_oe <= active && tx_on;
    end
  end
endmodule

// File: rtl/sermem_array.sv
module sermem_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/sermem_ctrl.sv
module sermem_ctrl
  import sermem_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          desel,
  input  logic          wp_q,
  input  logic          byte_vld,
  input  logic [7:0]    byte_data,
  output logic          tx_on,
  output logic [7:0]    tx_byte,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata
);
  localparam int HI_W = AW - 8;

  phase_t          phase;
  logic [7:0]      op;
  logic [HI_W-1:0] addr_hi;
  logic [AW-1:0]   addr;
  logic            wel, wpen, wr_done, tx_sel, fetch, prot;
  logic [1:0]      bp;
  logic            wr_byte, sr_byte;
  logic [7:0]      status;

  always_comb begin
    case (bp)
      2'b00:   prot = 1'b0;
      2'b01:   prot = &addr[AW-1:AW-2];
      2'b10:   prot = addr[AW-1];
      default: prot = 1'b1;
    endcase
  end

  assign wr_byte   = byte_vld && phase == PH_DATA && op == OP_WRITE;
  assign sr_byte   = byte_vld && phase == PH_AH && op == OP_WRSR;
  assign status    = {wpen, 3'b000, bp, wel, 1'b0};
  assign tx_byte   = tx_sel ? mem_rdata : status;
  assign mem_we    = wr_byte && wel && !prot;
  assign mem_re    = fetch;
  assign mem_addr  = addr;
  assign mem_wdata = byte_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_OP;
      op      <= '0;
      addr_hi <= '0;
      addr    <= '0;
      wel     <= 1'b0;
      wpen    <= 1'b0;
      bp      <= '0;
      wr_done <= 1'b0;
      tx_sel  <= 1'b0;
      tx_on   <= 1'b0;
      fetch   <= 1'b0;
    end else begin
      fetch <= 1'b0;
      if (byte_vld) begin
        if (phase != PH_DATA) phase <= phase_t'(phase + 2'd1);
        case (phase)
          PH_OP: begin
            op <= byte_data;
            case (byte_data)
              OP_WREN: wel <= 1'b1;
              OP_WRDI: wel <= 1'b0;
              OP_RDSR: begin tx_on <= 1'b1; tx_sel <= 1'b0; end
              default: ;
            endcase
          end
          PH_AH: begin
            addr_hi <= byte_data[HI_W-1:0];
            if (op == OP_WRSR && wel && !(wpen && !wp_q)) begin
              wpen <= byte_data[7];
              bp   <= byte_data[3:2];
            end
          end
          PH_AL: begin
            addr <= {addr_hi, byte_data};
            if (op == OP_READ) begin
              fetch  <= 1'b1;
              tx_on  <= 1'b1;
              tx_sel <= 1'b1;
            end
          end
          default: begin
            if (op == OP_READ || op == OP_WRITE) addr <= addr + 1'b1;
            if (op == OP_READ) fetch <= 1'b1;
          end
        endcase
        if (wr_byte || sr_byte) wr_done <= 1'b1;
      end
      // deselect wins over a byte finishing in the same cycle, but keeps its effect on the latch
      if (desel) begin
        phase   <= PH_OP;
        op      <= '0;
        tx_on   <= 1'b0;
        wr_done <= 1'b0;
        if (wr_done || wr_byte || sr_byte) wel <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sermem_slave.sv
module sermem_slave #(
  parameter int ADDR_W = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);
  logic              desel, wp_q, byte_vld, tx_on;
  logic [7:0]        byte_data, tx_byte, mem_wdata, mem_rdata;
  logic              mem_we, mem_re;
  logic [ADDR_W-1:0] mem_addr;

  sermem_port u_port (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .wp_n(wp_n), .tx_on(tx_on), .tx_byte(tx_byte), .desel(desel), .wp_q(wp_q),
    .byte_vld(byte_vld), .byte_data(byte_data), .so(so), .so_oe(so_oe)
  );

  sermem_ctrl #(.AW(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .desel(desel), .wp_q(wp_q), .byte_vld(byte_vld),
    .byte_data(byte_data), .tx_on(tx_on), .tx_byte(tx_byte), .mem_we(mem_we),
    .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  sermem_array #(.AW(ADDR_W), .DW(8)) u_array (
    .clk(clk), .we(mem_we), .re(mem_re), .addr(mem_addr),
    .wdata(mem_wdata), .rdata(mem_rdata)
  );
endmodule

// File: rtl/sermem_checker.sv
module sermem_checker (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       hold_n,
  input logic       so_oe,
  input logic       cs_q,
  input logic       hold_q,
  input logic       wp_q,
  input logic       wel,
  input logic       wpen,
  input logic [1:0] bp,
  input logic [2:0] bit_cnt
);
  // R8: a deselected slave releases its output two clocks later
  a_r8_deselect_hiz: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> ##2 !so_oe);

  // R9: pause releases the output
  a_r9_hold_hiz: assert property (@(posedge clk) disable iff (rst)
    !hold_n |-> ##2 !so_oe);

  // R9: bit position frozen while paused
  a_r9_hold_freeze: assert property (@(posedge clk) disable iff (rst)
    (!hold_q && !cs_q) |=> $stable(bit_cnt));

  // R6: status bits move only with the latch set
  a_r6_bp_needs_wel: assert property (@(posedge clk) disable iff (rst)
    !$stable({wpen, bp}) |-> $past(wel));

  // R6: locked status stays put while wp_n is low
  a_r6_wp_lock: assert property (@(posedge clk) disable iff (rst)
    !$stable({wpen, bp}) |-> !($past(wpen) && !$past(wp_q)));
endmodule

bind sermem_slave sermem_checker u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .hold_n(hold_n), .so_oe(so_oe),
  .cs_q(u_port.cs_q), .hold_q(u_port.hold_q), .wp_q(u_port.wp_q),
  .wel(u_ctrl.wel), .wpen(u_ctrl.wpen), .bp(u_ctrl.bp),
  .bit_cnt(u_port.bit_cnt)
);

// File: tb/sermem_slave_test.sv
module sermem_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 5;
  localparam int NVEC = 10;
  // {protect field, address, write data, expected read-back}
  localparam logic [33:0] VEC [NVEC] = '{
    {2'd0, 16'h0010, 8'hA5, 8'hA5},
    {2'd0, 16'h0600, 8'h11, 8'h11},
    {2'd0, 16'h0400, 8'h22, 8'h22},
    {2'd0, 16'h07FF, 8'h33, 8'h33},
    {2'd1, 16'h0600, 8'h44, 8'h11},
    {2'd1, 16'h0400, 8'h55, 8'h55},
    {2'd2, 16'h0400, 8'h66, 8'h55},
    {2'd2, 16'h0010, 8'h77, 8'h77},
    {2'd3, 16'h0010, 8'h88, 8'h77},
    {2'd0, 16'hF810, 8'h99, 8'h99}
  };

  logic clk = 0, rst = 1, cs_n = 1, sck = 0, si = 0, hold_n = 1, wp_n = 1;
  logic so, so_oe;
  int   checks = 0, fails = 0;
  logic oe_any = 0, hold_oe = 0, addr_oe = 0;
  logic [7:0] junk, r, r2;

  always #(CLK_PERIOD/2) clk = ~clk;

  sermem_slave uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                      input int hold_at = -1, input bit fast = 0);
    for (int i = 7; i >= 0; i--) begin
      if (i == hold_at) begin
        hold_n = 0;
        repeat (3) @(negedge clk);
        hold_oe = so_oe;
        for (int k = 0; k < 2; k++) begin
          si = ~si; sck = 1; repeat (HALF) @(negedge clk);
          sck = 0; repeat (HALF) @(negedge clk);
        end
        hold_n = 1;
        repeat (HALF) @(negedge clk);
      end
      si = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = so;
      oe_any |= so_oe;
      sck = 1;
      if (fast && i == 0) begin @(negedge clk); cs_n = 1; end
      repeat (HALF) @(negedge clk);
      sck = 0;
    end
  endtask

  task automatic sel();
    cs_n = 0; repeat (HALF) @(negedge clk);
  endtask
  task automatic unsel();
    repeat (HALF) @(negedge clk); cs_n = 1; repeat (2*HALF) @(negedge clk);
  endtask
  task automatic cmd(input logic [7:0] op);
    sel(); xfer(op, junk); unsel();
  endtask
  task automatic wrsr(input logic [7:0] v);
    sel(); xfer(8'h01, junk); xfer(v, junk); unsel();
  endtask
  task automatic rdsr(output logic [7:0] v);
    sel(); xfer(8'h05, junk); xfer(8'h00, v); unsel();
  endtask
  task automatic write1(input logic [15:0] a, input logic [7:0] d, input bit fast = 0);
    sel(); xfer(8'h02, junk); xfer(a[15:8], junk); xfer(a[7:0], junk);
    xfer(d, junk, -1, fast);
    if (fast) repeat (3*HALF) @(negedge clk); else unsel();
  endtask
  task automatic read1(input logic [15:0] a, output logic [7:0] d);
    sel(); oe_any = 0;
    xfer(8'h03, junk); xfer(a[15:8], junk); xfer(a[7:0], junk);
    addr_oe = oe_any;
    xfer(8'h00, d); unsel();
  endtask

  initial begin
    repeat (200000 - 50) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (4) @(negedge clk);
    chk("R8 so_oe after reset", {7'b0, so_oe}, 8'h00);
    rdsr(r);
    chk("R5 status after reset", r, 8'h00);

    // table walk: protect field, write, immediate read-back
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] bp; logic [15:0] a; logic [7:0] d, e;
      {bp, a, d, e} = VEC[v];
      cmd(8'h06); wrsr({4'b0, bp, 2'b0});
      cmd(8'h06); write1(a, d);
      read1({5'b0, a[10:0]}, r);
      chk($sformatf("R1/R3/R7/R12 vector %0d", v), r, e);
      chk("R8 so_oe in address phase", {7'b0, addr_oe}, 8'h00);
      rdsr(r);
      chk("R4 latch cleared after write", r, {4'b0, bp, 2'b0});
    end

    // R3: write without latch ignored
    write1(16'h0010, 8'h5A);
    read1(16'h0010, r);
    chk("R3 write without latch", r, 8'h99);

    // R4: WREN / WRDI
    cmd(8'h06); rdsr(r);
    chk("R4 WREN sets latch", r, 8'h02);
    cmd(8'h04); rdsr(r);
    chk("R4 WRDI clears latch", r, 8'h00);

    // R6: WRSR without latch, then lock with wp_n
    wrsr(8'h0C); rdsr(r);
    chk("R6 WRSR without latch", r, 8'h00);
    cmd(8'h06); wrsr(8'h80); rdsr(r);
    chk("R6 lock bit set", r, 8'h80);
    wp_n = 0;
    cmd(8'h06); wrsr(8'h8C); rdsr(r);
    chk("R6 WRSR refused with wp_n low", r, 8'h80);
    wp_n = 1;
    cmd(8'h06); wrsr(8'h00); rdsr(r);
    chk("R6 WRSR accepted with wp_n high", r, 8'h00);

    // R10: unknown opcode
    cmd(8'h06);
    sel(); oe_any = 0;
    xfer(8'hAB, junk); xfer(8'h00, junk); xfer(8'h10, junk); xfer(8'hFF, junk);
    chk("R8/R10 so_oe for unknown opcode", {7'b0, oe_any}, 8'h00);
    unsel();
    rdsr(r);
    chk("R10 latch kept after unknown opcode", r, 8'h02);
    read1(16'h0010, r);
    chk("R10 array kept after unknown opcode", r, 8'h99);

    // R2/R3: burst across the top of the array
    cmd(8'h06);
    sel(); xfer(8'h02, junk); xfer(8'h07, junk); xfer(8'hFF, junk);
    xfer(8'hAA, junk); xfer(8'hBB, junk); unsel();
    sel(); xfer(8'h03, junk); xfer(8'h07, junk); xfer(8'hFF, junk);
    xfer(8'h00, r); xfer(8'h00, r2); unsel();
    chk("R2 burst read top byte", r, 8'hAA);
    chk("R2/R3 burst wrapped to zero", r2, 8'hBB);

    // R9: pause inside a write byte and inside a read byte
    cmd(8'h06);
    sel(); xfer(8'h02, junk); xfer(8'h00, junk); xfer(8'h40, junk);
    xfer(8'h3C, junk, 4); unsel();
    sel(); xfer(8'h03, junk); xfer(8'h00, junk); xfer(8'h40, junk);
    xfer(8'h00, r, 3);
    chk("R9 so_oe during pause", {7'b0, hold_oe}, 8'h00);
    chk("R9 so_oe after pause", {7'b0, so_oe}, 8'h01);
    unsel();
    chk("R9 read across pause", r, 8'h3C);
    read1(16'h0040, r);
    chk("R9 write across pause", r, 8'h3C);
    chk("R8 so_oe while deselected", {7'b0, so_oe}, 8'h00);

    // R11: final edge and deselect in adjacent clocks
    cmd(8'h06);
    write1(16'h0030, 8'h5A, 1);
    rdsr(r);
    chk("R11 latch cleared on fast release", r, 8'h00);
    read1(16'h0030, r);
    chk("R11 byte stored on fast release", r, 8'h5A);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule